// File: doc/BRIEF.md
# Palette Colour Table Host Port

This block holds a 256-entry colour lookup table, each entry made of three 6-bit components (red, green, blue). A host reaches the table through a small byte-wide register window. The host first loads an entry pointer through one of two address registers. One register prepares the table for writing and the other prepares it for reading. The host then moves components through a single data register, always red first, then green, then blue. After the blue component the pointer steps to the next entry, so a run of consecutive entries can be streamed without setting the address again. An 8-bit pixel mask register and a read-only state register complete the window. The state register tells software which kind of address was loaded last.

A separate lookup port serves the display side. It takes a pixel index, ANDs it with the pixel mask, and returns the packed colour of the selected entry one clock later. The host side and the lookup side work independently and may be active in the same cycle.

Top module: `pal_dac_port`

## Requirements
- R1: After a write to the write-address register (select code 0), the next three writes to the data register (select code 2) store red, green and blue of the addressed entry, in that order.
- R2: After a write to the read-address register (select code 1), reads of the data register return red, green and blue of the addressed entry, in that order. Read data appears on `host_rdata` in the clock cycle after the cycle in which `host_rd` is sampled. When `host_wr` and `host_rd` are both high, only the write is performed.
- R3: Each third data-register access (read or write) advances the entry pointer by one and restarts at red, so consecutive entries stream without re-addressing. Reading select code 0 or 1 returns the current entry pointer.
- R4: The entry pointer wraps from 255 to 0.
- R5: A write to either address register returns the component position to red, even in the middle of an entry.
- R6: A data write keeps only bits 5:0 of the byte. A data read returns the 6-bit component with bits 7:6 zero.
- R7: The pixel mask register (select code 3) can be written and read back. Its reset value is 0xFF.
- R8: The state register (select code 4) reads 0x03 after a read-address write, and 0x00 after a write-address write or after reset. Writes to it are ignored.
- R9: `pix_rgb` shows entry (`pix_idx` AND mask) one cycle after `pix_idx` is sampled, packed as red in bits 17:12, green in bits 11:6 and blue in bits 5:0.
- R10: When a lookup and a host data write address the same component of the same entry in one cycle, the lookup returns the value from before the write. The next lookup returns the new value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_sel | input | 3 | Register select: 0 write address, 1 read address, 2 data, 3 pixel mask, 4 state |
| host_wr | input | 1 | Host write strobe, one access per cycle |
| host_rd | input | 1 | Host read strobe, one access per cycle |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, registered, held between reads |
| pix_idx | input | 8 | Pixel index for the lookup port |
| pix_rgb | output | 18 | Looked-up colour {red, green, blue} |

## Verification
The host data port and the lookup port can touch the same table entry in the same cycle. The bench provokes this by loading red and green of an entry and then presenting that entry's index on `pix_idx` in the very cycle the blue component is written. The result is judged in two steps. The first lookup result must combine the new red and green with the old blue. The result one cycle later must show all three new components. The full sweeps also run lookups under several mask values right after streamed host accesses, so the two paths are checked while sharing the table contents.

// File: rtl/pal_dac_pkg.sv
// Package: pal_dac_pkg
// Shared encodings for the palette colour table port: host register
// select codes, component position and address mode.
// Assumes an 8-bit host bus; table geometry is parameterised per module.
package pal_dac_pkg;

    localparam int BUS_W = 8;

    // Host register select codes (visible at the host_sel port).
    typedef enum logic [2:0] {
        SEL_WADDR = 3'd0,
        SEL_RADDR = 3'd1,
        SEL_DATA  = 3'd2,
        SEL_MASK  = 3'd3,
        SEL_STATE = 3'd4
    } port_sel_e;

    // Component position within one entry.
    typedef enum logic [1:0] {
        COMP_R = 2'd0,
        COMP_G = 2'd1,
        COMP_B = 2'd2
    } comp_e;

    // Kind of address loaded last.
    typedef enum logic {
        MODE_WR = 1'b0,
        MODE_RD = 1'b1
    } mode_e;

    localparam logic [BUS_W-1:0] STATE_CODE_RD = 8'h03;
    localparam logic [BUS_W-1:0] STATE_CODE_WR = 8'h00;

endpackage

// File: rtl/pal_dac_ptr.sv
// Module: pal_dac_ptr
// Entry pointer, component position and address mode for the host port.
// An address load sets the pointer, restarts at red and records the mode.
// Each data access steps the component position; after blue the pointer
// advances by one and wraps at the top of the table.
// Assumes addr_wr and data_step never assert together (the caller decodes
// them from one select code); addr_wr takes priority if they do.
module pal_dac_ptr
    import pal_dac_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             addr_wr,
    input  logic             addr_is_rd,
    input  logic [IDX_W-1:0] addr_val,
    input  logic             data_step,
    output logic [IDX_W-1:0] ptr,
    output comp_e            comp,
    output mode_e            mode
);

    localparam logic [IDX_W-1:0] PTR_TOP = {IDX_W{1'b1}};

    // Pointer, component position and mode update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr  <= '0;
            comp <= COMP_R;
            mode <= MODE_WR;
        end else if (addr_wr) begin
            ptr  <= addr_val;
            comp <= COMP_R;
            mode <= addr_is_rd ? MODE_RD : MODE_WR;
        end else if (data_step) begin
            case (comp)
                COMP_R:  comp <= COMP_G;
                COMP_G:  comp <= COMP_B;
                default: begin
                    comp <= COMP_R;
                    ptr  <= ptr + 1'b1;
                end
            endcase
        end
    end

    // R3: component position never leaves R/G/B.
    a_r3_comp_legal: assert property (@(posedge clk) disable iff (!rst_n)
        comp != 2'd3);

    // R3: third access advances the pointer and restarts at red.
    a_r3_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (data_step && !addr_wr && comp == COMP_B)
        |=> (ptr == $past(ptr) + 1'b1) && (comp == COMP_R));

    // R3: first and second accesses leave the pointer alone.
    a_r3_hold_ptr: assert property (@(posedge clk) disable iff (!rst_n)
        (data_step && !addr_wr && comp != COMP_B) |=> $stable(ptr));

    // R4: pointer wraps from the top entry to zero.
    a_r4_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (data_step && !addr_wr && comp == COMP_B && ptr == PTR_TOP)
        |=> ptr == '0);

    // R5: any address load restarts at red.
    a_r5_restart: assert property (@(posedge clk) disable iff (!rst_n)
        addr_wr |=> comp == COMP_R);

    // R8: mode changes only on an address load.
    a_r8_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_wr |=> $stable(mode));

endmodule

// File: rtl/pal_dac_table.sv
// Module: pal_dac_table
// Colour table storage: one plane per component, each with a host write
// port, a combinational host read port and a registered lookup port.
// The lookup register samples the planes before a same-cycle write lands,
// so a colliding lookup sees the old value.
// Assumes at most one component written per cycle.
module pal_dac_table
    import pal_dac_pkg::*;
#(
    parameter int IDX_W  = 8,
    parameter int COMP_W = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [IDX_W-1:0]      wr_idx,
    input  comp_e                 wr_comp,
    input  logic [COMP_W-1:0]     wr_val,
    input  logic [IDX_W-1:0]      hrd_idx,
    input  comp_e                 hrd_comp,
    output logic [COMP_W-1:0]     hrd_val,
    input  logic [IDX_W-1:0]      lk_idx,
    output logic [3*COMP_W-1:0]   lk_rgb
);

    localparam int DEPTH   = 1 << IDX_W;
    localparam int NPLANES = 3;

    logic [COMP_W-1:0] plane_rd [NPLANES];
    logic [COMP_W-1:0] plane_lk [NPLANES];

    // One storage plane per component.
    for (genvar c = 0; c < NPLANES; c++) begin : g_plane
        logic [COMP_W-1:0] mem [DEPTH];

        // Host write into this plane when its component is selected.
        always_ff @(posedge clk) begin
            if (wr_en && (wr_comp == comp_e'(c))) begin
                mem[wr_idx] <= wr_val;
            end
        end

        assign plane_rd[c] = mem[hrd_idx];
        assign plane_lk[c] = mem[lk_idx];
    end

    // Host read select among the three planes.
    always_comb begin
        case (hrd_comp)
            COMP_R:  hrd_val = plane_rd[0];
            COMP_G:  hrd_val = plane_rd[1];
            default: hrd_val = plane_rd[2];
        endcase
    end

    // Registered lookup result, red in the top field.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lk_rgb <= '0;
        end else begin
            lk_rgb <= {plane_lk[0], plane_lk[1], plane_lk[2]};
        end
    end

    // R10: a colliding write does not show in the same-cycle lookup.
    a_r10_read_first: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_comp == COMP_B && lk_idx == wr_idx)
        |=> lk_rgb[COMP_W-1:0] == $past(plane_lk[2]));

endmodule

// File: rtl/pal_dac_port.sv
// Module: pal_dac_port
// Host register window and pixel lookup port for a colour table of
// 2**IDX_W entries with three COMP_W-bit components.
// Decodes the host select code into pointer loads, data steps, mask
// writes and registered read data; masks the pixel index for lookup.
// Assumes IDX_W <= 8 and COMP_W <= 8 (8-bit host bus), one host access
// per cycle; a write wins over a read presented in the same cycle.
module pal_dac_port
    import pal_dac_pkg::*;
#(
    parameter int          IDX_W      = 8,
    parameter int          COMP_W     = 6,
    parameter logic [7:0]  MASK_RESET = 8'hFF
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2:0]          host_sel,
    input  logic                host_wr,
    input  logic                host_rd,
    input  logic [7:0]          host_wdata,
    output logic [7:0]          host_rdata,
    input  logic [IDX_W-1:0]    pix_idx,
    output logic [3*COMP_W-1:0] pix_rgb
);

    port_sel_e         sel;
    logic              wr_go;
    logic              rd_go;
    logic              addr_wr;
    logic              addr_is_rd;
    logic              data_step;
    logic              tbl_wr;
    logic [IDX_W-1:0]  ptr;
    comp_e             comp;
    mode_e             mode;
    logic [IDX_W-1:0]  mask;
    logic [COMP_W-1:0] hrd_val;
    logic [IDX_W-1:0]  lk_idx;

    // Host strobe and select decode.
    always_comb begin
        sel        = port_sel_e'(host_sel);
        wr_go      = host_wr;
        rd_go      = host_rd && !host_wr;
        addr_wr    = wr_go && (sel == SEL_WADDR || sel == SEL_RADDR);
        addr_is_rd = (sel == SEL_RADDR);
        data_step  = (wr_go || rd_go) && (sel == SEL_DATA);
        tbl_wr     = wr_go && (sel == SEL_DATA);
        lk_idx     = pix_idx & mask;
    end

    pal_dac_ptr #(
        .IDX_W (IDX_W)
    ) u_ptr (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_wr    (addr_wr),
        .addr_is_rd (addr_is_rd),
        .addr_val   (host_wdata[IDX_W-1:0]),
        .data_step  (data_step),
        .ptr        (ptr),
        .comp       (comp),
        .mode       (mode)
    );

    pal_dac_table #(
        .IDX_W  (IDX_W),
        .COMP_W (COMP_W)
    ) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (tbl_wr),
        .wr_idx   (ptr),
        .wr_comp  (comp),
        .wr_val   (host_wdata[COMP_W-1:0]),
        .hrd_idx  (ptr),
        .hrd_comp (comp),
        .hrd_val  (hrd_val),
        .lk_idx   (lk_idx),
        .lk_rgb   (pix_rgb)
    );

    // Pixel mask register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask <= MASK_RESET[IDX_W-1:0];
        end else if (wr_go && sel == SEL_MASK) begin
            mask <= host_wdata[IDX_W-1:0];
        end
    end

    // Registered host read data, held between reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_rdata <= '0;
        end else if (rd_go) begin
            case (sel)
                SEL_WADDR, SEL_RADDR: host_rdata <= BUS_W'(ptr);
                SEL_DATA:             host_rdata <= BUS_W'(hrd_val);
                SEL_MASK:             host_rdata <= BUS_W'(mask);
                SEL_STATE:            host_rdata <= (mode == MODE_RD) ?
                                                    STATE_CODE_RD :
                                                    STATE_CODE_WR;
                default:              host_rdata <= '0;
            endcase
        end
    end

    // R2: read data changes only after a performed read.
    a_r2_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_go |=> $stable(host_rdata));

    // R6: data reads come back zero-extended.
    a_r6_zero_ext: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_go && sel == SEL_DATA) |=> host_rdata[7:COMP_W] == '0);

    // R7: mask changes only on a mask write.
    a_r7_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_go && sel == SEL_MASK) |=> $stable(mask));

    // R8: state reads return one of the two legal codes.
    a_r8_state_code: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_go && sel == SEL_STATE)
        |=> (host_rdata == STATE_CODE_RD || host_rdata == STATE_CODE_WR));

endmodule

// File: tb/pal_dac_port_tb.sv
`timescale 1ns/1ps
module pal_dac_port_tb;

    localparam logic [2:0] S_WA = 3'd0;
    localparam logic [2:0] S_RA = 3'd1;
    localparam logic [2:0] S_DT = 3'd2;
    localparam logic [2:0] S_MK = 3'd3;
    localparam logic [2:0] S_ST = 3'd4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  host_sel = '0;
    logic        host_wr = 1'b0;
    logic        host_rd = 1'b0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata;
    logic [7:0]  pix_idx = '0;
    logic [17:0] pix_rgb;

    int checks = 0;
    int fails  = 0;

    logic [5:0] exp_r [256];
    logic [5:0] exp_g [256];
    logic [5:0] exp_b [256];

    always #2.5 clk = ~clk;

    pal_dac_port u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_sel   (host_sel),
        .host_wr    (host_wr),
        .host_rd    (host_rd),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .pix_idx    (pix_idx),
        .pix_rgb    (pix_rgb)
    );

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [2:0] s, input logic [7:0] d);
        @(negedge clk);
        host_sel = s; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic bus_rd(input logic [2:0] s, output logic [7:0] v);
        @(negedge clk);
        host_sel = s; host_rd = 1'b1;
        @(negedge clk);
        host_rd = 1'b0;
        v = host_rdata;
    endtask

    function automatic logic [17:0] pack(input int i);
        return {exp_r[i], exp_g[i], exp_b[i]};
    endfunction

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] v;
        logic [5:0] old_b;
        for (int i = 0; i < 256; i++) begin
            exp_r[i] = 6'((i * 7 + 3) % 64);
            exp_g[i] = 6'((i * 13 + 29) % 64);
            exp_b[i] = 6'((300 - i) % 64);
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // Reset state
        bus_rd(S_ST, v); check("R8 reset state", v, 8'h00);
        bus_rd(S_MK, v); check("R7 reset mask", v, 8'hFF);
        bus_rd(S_WA, v); check("R3 reset pointer", v, 8'h00);

        // Stream all entries in, upper bits set to test truncation (R1, R6)
        bus_wr(S_WA, 8'h00);
        bus_rd(S_ST, v); check("R8 state after write address", v, 8'h00);
        for (int i = 0; i < 256; i++) begin
            bus_wr(S_DT, {2'b11, exp_r[i]});
            bus_wr(S_DT, {2'b10, exp_g[i]});
            bus_wr(S_DT, {2'b01, exp_b[i]});
        end
        bus_rd(S_WA, v); check("R4 pointer wrapped after 256 writes", v, 8'h00);

        // Stream all entries out (R2, R3, R6)
        bus_wr(S_RA, 8'h00);
        bus_rd(S_ST, v); check("R8 state after read address", v, 8'h03);
        for (int i = 0; i < 256; i++) begin
            bus_rd(S_DT, v); check("R2 read red", v, {2'b00, exp_r[i]});
            bus_rd(S_DT, v); check("R2 read green", v, {2'b00, exp_g[i]});
            bus_rd(S_DT, v); check("R2 read blue", v, {2'b00, exp_b[i]});
        end
        bus_rd(S_RA, v); check("R4 pointer wrapped after 256 reads", v, 8'h00);

        // Read stream across the top of the table (R3, R4)
        bus_wr(S_RA, 8'd254);
        for (int i = 254; i < 257; i++) begin
            bus_rd(S_DT, v); check("R4 wrap read red", v, {2'b00, exp_r[i % 256]});
            bus_rd(S_DT, v); check("R4 wrap read green", v, {2'b00, exp_g[i % 256]});
            bus_rd(S_DT, v); check("R4 wrap read blue", v, {2'b00, exp_b[i % 256]});
        end
        bus_rd(S_RA, v); check("R3 pointer after wrap stream", v, 8'h01);

        // Address reload mid-entry restarts at red (R5)
        bus_wr(S_WA, 8'd40);
        bus_wr(S_DT, 8'h11); exp_r[40] = 6'h11;
        bus_wr(S_WA, 8'd40);
        bus_wr(S_DT, 8'h21); exp_r[40] = 6'h21;
        bus_wr(S_DT, 8'h22); exp_g[40] = 6'h22;
        bus_wr(S_DT, 8'h23); exp_b[40] = 6'h23;
        bus_wr(S_RA, 8'd40);
        bus_rd(S_DT, v); check("R5 first red", v, 8'h21);
        bus_wr(S_RA, 8'd40);
        bus_rd(S_DT, v); check("R5 red after reload", v, 8'h21);
        bus_rd(S_DT, v); check("R5 green after reload", v, 8'h22);
        bus_rd(S_DT, v); check("R5 blue after reload", v, 8'h23);
        bus_rd(S_WA, v); check("R3 pointer after one entry", v, 8'd41);

        // State register ignores writes (R8)
        bus_wr(S_ST, 8'hFF);
        bus_rd(S_ST, v); check("R8 state write ignored", v, 8'h03);

        // Write wins over a simultaneous read (R2)
        bus_rd(S_MK, v);
        @(negedge clk);
        host_sel = S_MK; host_wdata = 8'h3C; host_wr = 1'b1; host_rd = 1'b1;
        @(negedge clk);
        host_wr = 1'b0; host_rd = 1'b0;
        check("R2 read dropped when write present", host_rdata, 8'hFF);
        bus_wr(S_MK, 8'hFF);

        // Lookup sweeps under several masks (R7, R9)
        for (int m = 0; m < 3; m++) begin
            logic [7:0] mk;
            mk = (m == 0) ? 8'hFF : ((m == 1) ? 8'h0F : 8'hA5);
            bus_wr(S_MK, mk);
            bus_rd(S_MK, v); check("R7 mask readback", v, mk);
            for (int i = 0; i < 256; i++) begin
                @(negedge clk);
                pix_idx = 8'(i);
                @(negedge clk);
                check("R9 lookup", pix_rgb, pack(i & mk));
            end
        end
        bus_wr(S_MK, 8'hFF);

        // Collision of lookup and blue write on one entry (R10)
        bus_wr(S_WA, 8'd20);
        bus_wr(S_DT, 8'h05); exp_r[20] = 6'h05;
        bus_wr(S_DT, 8'h06); exp_g[20] = 6'h06;
        old_b = exp_b[20];
        @(negedge clk);
        host_sel = S_DT; host_wdata = 8'h07; host_wr = 1'b1; pix_idx = 8'd20;
        @(negedge clk);
        host_wr = 1'b0;
        check("R10 colliding lookup sees old blue", pix_rgb,
              {6'h05, 6'h06, old_b});
        exp_b[20] = 6'h07;
        @(negedge clk);
        check("R10 next lookup sees new blue", pix_rgb, pack(20));

        finish_run();
    end

endmodule